// File: doc/BRIEF.md
# Vector Instruction Issue Handshake Controller

This block sits between a scalar core and a vector backend. The core hands over one vector instruction at a time on a valid/ready request channel. By the time an instruction arrives it is already committed on the core side. A decode stage upstream supplies the instruction's class (arithmetic, configuration, load or store), a legality verdict and a whole-register flag. The controller uses these together with a flag saying the current vector length is zero. For each instruction it decides whether to forward the payload to the backend, and it decides when the core may have its response.

Arithmetic and configuration instructions can only fault at decode, so they are answered in the cycle they are accepted. An illegal instruction is also answered at once, with the exception flag set, and nothing goes to the backend. A memory instruction is forwarded, but its response waits until the load/store unit reports a clean finish of the matching kind, or reports an exception. Until then no new instruction is taken. When the vector length is zero, most instructions are completed as no-ops in the cycle they are accepted; whole-register operations are the exception and take their normal path. After any exception response, the controller refuses new work until the backend reports idle.

Top module: `vec_issue_ctrl`

## Requirements
- R1: After synchronous active-low reset the controller is idle: request ready is 1, backend valid is 0, response valid is 0, and the held backend payload is 0.
- R2: A legal arithmetic (class 2'b00) or configuration (class 2'b11) instruction with non-zero vector length gets response valid with exception 0 in its accept cycle, and the backend valid rises in the next cycle carrying the accepted payload.
- R3: An immediate response (arithmetic, configuration, no-op or illegal) reports result valid equal to the request's result-enable and carries the request's scalar result; a memory response has result valid 0 and a result of 0.
- R4: Accepting a legal load (class 2'b01) or store (class 2'b10) gives no response in that cycle, and request ready stays 0 until its completion response.
- R5: A waiting load completes only on load-done, and a waiting store only on store-done; the other done signal is ignored. A memory exception ends either kind. Completion inputs are considered only once the backend has taken the request. The response is given in the cycle the completion is seen, with exception equal to the memory-exception input.
- R6: An illegal instruction gets response valid with exception 1 in its accept cycle, and no backend request is raised for it.
- R7: With the zero-length flag set, a legal instruction without the whole-register flag is completed in its accept cycle with exception 0 and is not forwarded. An illegal instruction still takes the illegal path.
- R8: A whole-register instruction is forwarded and handled by its class even when the zero-length flag is set.
- R9: After any response with exception 1, request ready stays 0 until backend-idle is seen high; it returns to 1 in the following cycle.
- R10: Once raised, backend valid stays 1 with a stable payload until backend ready is seen high.
- R11: Request ready is 1 only when the controller is idle and its backend slot is empty or being taken in that cycle, so at most one instruction is outstanding toward the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_req_valid_i | input | 1 | Core offers an instruction |
| core_req_ready_o | output | 1 | Controller takes the instruction this cycle |
| core_req_class_i | input | 2 | 00 arithmetic, 01 load, 10 store, 11 configuration |
| core_req_illegal_i | input | 1 | Decode verdict: instruction is illegal |
| core_req_whole_reg_i | input | 1 | Whole-register operation |
| core_req_payload_i | input | PAYLOAD_W | Decoded request forwarded to the backend |
| core_req_result_en_i | input | 1 | Instruction returns a scalar result |
| core_req_result_i | input | XLEN | Scalar result for the response |
| vl_zero_i | input | 1 | Current vector length is zero |
| core_resp_valid_o | output | 1 | Response to the core |
| core_resp_exc_o | output | 1 | Response carries an exception |
| core_resp_result_valid_o | output | 1 | Response carries a scalar result |
| core_resp_result_o | output | XLEN | Scalar result |
| be_req_valid_o | output | 1 | Backend request valid |
| be_req_ready_i | input | 1 | Backend takes the request |
| be_req_payload_o | output | PAYLOAD_W | Backend request payload |
| mem_load_done_i | input | 1 | Load finished without fault |
| mem_store_done_i | input | 1 | Store finished without fault |
| mem_exc_i | input | 1 | Memory operation faulted |
| be_idle_i | input | 1 | Backend is idle |

## Verification
A wrong control state shows at request ready in the very next cycle: a controller stuck waiting on memory or flushing holds ready low, and one that left a wait too early raises ready while a response is still owed. A wrong completion match shows as a missing or extra response in the cycle a done pulse arrives. A slot fault shows as backend valid dropping, or the payload changing, while backend ready is low. Because the bench compares every output every cycle, each such fault is reported within one clock of its cause.

// File: rtl/vic_pkg.sv
// Shared types for the vector issue handshake controller.
package vic_pkg;

    // Controller phase.
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_MEM   = 2'd1,
        ST_WAIT_FLUSH = 2'd2
    } ctrl_state_e;

    // Instruction class as delivered by the upstream decoder.
    typedef enum logic [1:0] {
        CLS_ARITH  = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_STORE  = 2'd2,
        CLS_CONFIG = 2'd3
    } instr_class_e;

    // Action chosen for an offered instruction.
    typedef enum logic [1:0] {
        ACT_ISSUE  = 2'd0,
        ACT_MEM    = 2'd1,
        ACT_NOOP   = 2'd2,
        ACT_REJECT = 2'd3
    } issue_act_e;

endpackage

// File: rtl/vic_classify.sv
// Chooses the action for the instruction on the request channel.
// Assumes the legality verdict and the class come from an upstream decoder.
// Priority: illegal, then the zero-length no-op, then class.
module vic_classify
    import vic_pkg::*;
(
    input  logic [1:0] cls_i,
    input  logic       illegal_i,
    input  logic       vl_zero_i,
    input  logic       whole_reg_i,
    output issue_act_e act_o,
    output logic       is_load_o
);

    logic is_mem;

    // Memory classes need a completion from the load/store unit.
    always_comb begin
        is_mem    = (cls_i == CLS_LOAD) || (cls_i == CLS_STORE);
        is_load_o = (cls_i == CLS_LOAD);
    end

    // Action selection in priority order.
    always_comb begin
        if (illegal_i) begin
            act_o = ACT_REJECT;
        end else if (vl_zero_i && !whole_reg_i) begin
            act_o = ACT_NOOP;
        end else if (is_mem) begin
            act_o = ACT_MEM;
        end else begin
            act_o = ACT_ISSUE;
        end
    end

endmodule

// File: rtl/vic_slot.sv
// Single-entry holding register for the backend request.
// Holds valid and payload until the backend takes it; a new load may
// replace an entry in the same cycle the backend takes it.
module vic_slot #(
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [PAYLOAD_W-1:0] data_i,
    input  logic                 take_i,
    output logic                 valid_o,
    output logic [PAYLOAD_W-1:0] data_o
);

    logic                 valid_q;
    logic [PAYLOAD_W-1:0] data_q;

    // Valid flag: set on load, cleared when the backend takes the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (load_i) begin
            valid_q <= 1'b1;
        end else if (valid_q && take_i) begin
            valid_q <= 1'b0;
        end
    end

    // Payload: captured only on load, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_i) begin
            data_q <= data_i;
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;

endmodule

// File: rtl/vic_fsm.sv
// Phase tracker: idle, waiting on a memory completion, or waiting for the
// backend to drain after an exception. Assumes accept_i is only high in idle.
// Completion inputs count only once the backend slot has emptied.
module vic_fsm
    import vic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept_i,
    input  issue_act_e  act_i,
    input  logic        is_load_i,
    input  logic        slot_empty_i,
    input  logic        load_done_i,
    input  logic        store_done_i,
    input  logic        mem_exc_i,
    input  logic        be_idle_i,
    output logic        idle_o,
    output logic        mem_resp_o
);

    ctrl_state_e state_q, state_d;
    logic        wait_load_q;
    logic        done_match;

    // Completion seen for the memory operation being waited on.
    always_comb begin
        done_match = wait_load_q ? load_done_i : store_done_i;
        mem_resp_o = (state_q == ST_WAIT_MEM) && slot_empty_i
                     && (done_match || mem_exc_i);
    end

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (accept_i && act_i == ACT_MEM) begin
                    state_d = ST_WAIT_MEM;
                end else if (accept_i && act_i == ACT_REJECT) begin
                    state_d = ST_WAIT_FLUSH;
                end
            end
            ST_WAIT_MEM: begin
                if (mem_resp_o) begin
                    state_d = mem_exc_i ? ST_WAIT_FLUSH : ST_IDLE;
                end
            end
            ST_WAIT_FLUSH: begin
                if (be_idle_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Remember which completion the memory wait needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_load_q <= 1'b0;
        end else if (accept_i && act_i == ACT_MEM) begin
            wait_load_q <= is_load_i;
        end
    end

    assign idle_o = (state_q == ST_IDLE);

endmodule

// File: rtl/vec_issue_ctrl.sv
// Top of the vector issue handshake controller.
// Takes committed, pre-decoded vector instructions from the core, forwards
// legal ones to the backend through a one-entry slot and times the core
// response by instruction class. Assumes the decoder output is stable while
// core_req_valid_i is high.
module vec_issue_ctrl
    import vic_pkg::*;
#(
    parameter int PAYLOAD_W = 32,
    parameter int XLEN      = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 core_req_valid_i,
    output logic                 core_req_ready_o,
    input  logic [1:0]           core_req_class_i,
    input  logic                 core_req_illegal_i,
    input  logic                 core_req_whole_reg_i,
    input  logic [PAYLOAD_W-1:0] core_req_payload_i,
    input  logic                 core_req_result_en_i,
    input  logic [XLEN-1:0]      core_req_result_i,
    input  logic                 vl_zero_i,
    output logic                 core_resp_valid_o,
    output logic                 core_resp_exc_o,
    output logic                 core_resp_result_valid_o,
    output logic [XLEN-1:0]      core_resp_result_o,
    output logic                 be_req_valid_o,
    input  logic                 be_req_ready_i,
    output logic [PAYLOAD_W-1:0] be_req_payload_o,
    input  logic                 mem_load_done_i,
    input  logic                 mem_store_done_i,
    input  logic                 mem_exc_i,
    input  logic                 be_idle_i
);

    issue_act_e act;
    logic       is_load;
    logic       idle;
    logic       mem_resp;
    logic       slot_valid;
    logic       slot_free;
    logic       accept;
    logic       slot_load;
    logic       imm_resp;

    vic_classify u_classify (
        .cls_i       (core_req_class_i),
        .illegal_i   (core_req_illegal_i),
        .vl_zero_i   (vl_zero_i),
        .whole_reg_i (core_req_whole_reg_i),
        .act_o       (act),
        .is_load_o   (is_load)
    );

    vic_slot #(.PAYLOAD_W(PAYLOAD_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (slot_load),
        .data_i  (core_req_payload_i),
        .take_i  (be_req_ready_i),
        .valid_o (slot_valid),
        .data_o  (be_req_payload_o)
    );

    vic_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .act_i        (act),
        .is_load_i    (is_load),
        .slot_empty_i (!slot_valid),
        .load_done_i  (mem_load_done_i),
        .store_done_i (mem_store_done_i),
        .mem_exc_i    (mem_exc_i),
        .be_idle_i    (be_idle_i),
        .idle_o       (idle),
        .mem_resp_o   (mem_resp)
    );

    // Request handshake: idle and the slot can take a new entry.
    always_comb begin
        slot_free        = !slot_valid || be_req_ready_i;
        core_req_ready_o = idle && slot_free;
        accept           = core_req_valid_i && core_req_ready_o;
        slot_load        = accept && (act == ACT_ISSUE || act == ACT_MEM);
        imm_resp         = accept && (act != ACT_MEM);
    end

    // Core response: immediate classes now, memory on completion.
    always_comb begin
        core_resp_valid_o        = imm_resp || mem_resp;
        core_resp_exc_o          = (accept && act == ACT_REJECT)
                                   || (mem_resp && mem_exc_i);
        core_resp_result_valid_o = imm_resp && core_req_result_en_i;
        core_resp_result_o       = core_resp_result_valid_o ? core_req_result_i
                                                            : '0;
    end

    assign be_req_valid_o = slot_valid;

endmodule

// File: rtl/vic_checker.sv
// Port-level properties of the issue controller, bound to the top module.
module vic_checker #(
    parameter int PAYLOAD_W = 32,
    parameter int XLEN      = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 core_req_valid_i,
    input logic                 core_req_ready_o,
    input logic [1:0]           core_req_class_i,
    input logic                 core_req_illegal_i,
    input logic                 core_req_whole_reg_i,
    input logic [PAYLOAD_W-1:0] core_req_payload_i,
    input logic                 vl_zero_i,
    input logic                 core_resp_valid_o,
    input logic                 core_resp_exc_o,
    input logic                 be_req_valid_o,
    input logic                 be_req_ready_i,
    input logic [PAYLOAD_W-1:0] be_req_payload_o
);

    logic acc, noop_case, mem_cls;

    always_comb begin
        acc       = core_req_valid_i && core_req_ready_o;
        noop_case = vl_zero_i && !core_req_whole_reg_i;
        mem_cls   = (core_req_class_i == 2'd1) || (core_req_class_i == 2'd2);
    end

    a_r2_imm_response: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !core_req_illegal_i && !noop_case && !mem_cls
        |-> core_resp_valid_o && !core_resp_exc_o);

    a_r2_imm_forward: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !core_req_illegal_i && !noop_case && !mem_cls
        |=> be_req_valid_o && be_req_payload_o == $past(core_req_payload_i));

    a_r4_mem_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !core_req_illegal_i && !noop_case && mem_cls
        |-> !core_resp_valid_o ##1 !core_req_ready_o);

    a_r6_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        acc && core_req_illegal_i |-> core_resp_valid_o && core_resp_exc_o);

    a_r6_reject_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        acc && core_req_illegal_i |=> !be_req_valid_o);

    a_r7_noop: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !core_req_illegal_i && noop_case
        |-> core_resp_valid_o && !core_resp_exc_o ##1 !be_req_valid_o);

    a_r9_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        core_resp_valid_o && core_resp_exc_o |=> !core_req_ready_o);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        be_req_valid_o && !be_req_ready_i
        |=> be_req_valid_o && $stable(be_req_payload_o));

    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        be_req_valid_o && !be_req_ready_i |-> !core_req_ready_o);

endmodule

bind vec_issue_ctrl vic_checker #(
    .PAYLOAD_W (PAYLOAD_W),
    .XLEN      (XLEN)
) u_vic_checker (
    .clk                  (clk),
    .rst_n                (rst_n),
    .core_req_valid_i     (core_req_valid_i),
    .core_req_ready_o     (core_req_ready_o),
    .core_req_class_i     (core_req_class_i),
    .core_req_illegal_i   (core_req_illegal_i),
    .core_req_whole_reg_i (core_req_whole_reg_i),
    .core_req_payload_i   (core_req_payload_i),
    .vl_zero_i            (vl_zero_i),
    .core_resp_valid_o    (core_resp_valid_o),
    .core_resp_exc_o      (core_resp_exc_o),
    .be_req_valid_o       (be_req_valid_o),
    .be_req_ready_i       (be_req_ready_i),
    .be_req_payload_o     (be_req_payload_o)
);

// File: tb/vec_issue_ctrl_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios for each requirement.
module vec_issue_ctrl_tb_top;

    localparam int PW = 32;
    localparam int XW = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, illegal, whole, res_en, vl_zero;
    logic [1:0]    cls;
    logic [PW-1:0] payload, be_payload;
    logic [XW-1:0] res_in, res_out;
    logic          resp_valid, resp_exc, res_valid;
    logic          be_valid, be_ready, ld_done, st_done, mexc, be_idle;

    always #10 clk = ~clk;

    vec_issue_ctrl #(.PAYLOAD_W(PW), .XLEN(XW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .core_req_valid_i(req_valid), .core_req_ready_o(req_ready),
        .core_req_class_i(cls), .core_req_illegal_i(illegal),
        .core_req_whole_reg_i(whole), .core_req_payload_i(payload),
        .core_req_result_en_i(res_en), .core_req_result_i(res_in),
        .vl_zero_i(vl_zero),
        .core_resp_valid_o(resp_valid), .core_resp_exc_o(resp_exc),
        .core_resp_result_valid_o(res_valid), .core_resp_result_o(res_out),
        .be_req_valid_o(be_valid), .be_req_ready_i(be_ready),
        .be_req_payload_o(be_payload),
        .mem_load_done_i(ld_done), .mem_store_done_i(st_done),
        .mem_exc_i(mexc), .be_idle_i(be_idle)
    );

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    // Reference model state: phase 0 idle, 1 memory wait, 2 flush wait.
    int            m_ph, n_ph;
    bit            m_sv, n_sv, m_ld, n_ld;
    logic [PW-1:0] m_sp, n_sp;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Compare all outputs with the model and compute its next state.
    task automatic probe();
        bit e_rdy, acc, hit, e_rv, e_exc, e_resv;
        int act;
        logic [XW-1:0] e_res;
        #5;
        if (!rst_n) return;
        e_rdy = (m_ph == 0) && (!m_sv || be_ready);
        acc   = req_valid && e_rdy;
        if (illegal) act = 3;
        else if (vl_zero && !whole) act = 2;
        else if (cls == 2'd1 || cls == 2'd2) act = 1;
        else act = 0;
        hit    = (m_ph == 1) && !m_sv && ((m_ld ? ld_done : st_done) || mexc);
        e_rv   = (acc && act != 1) || hit;
        e_exc  = acc ? (act == 3) : (hit && mexc);
        e_resv = acc && act != 1 && res_en;
        e_res  = e_resv ? res_in : '0;
        chk(req_ready == e_rdy, "R11 ready", req_ready, e_rdy);
        chk(resp_valid == e_rv, "R2 resp_valid", resp_valid, e_rv);
        chk(resp_exc == e_exc, "R6 resp_exc", resp_exc, e_exc);
        chk(res_valid == e_resv, "R3 result_valid", res_valid, e_resv);
        chk(res_out == e_res, "R3 result", res_out, e_res);
        chk(be_valid == m_sv, "R10 be_valid", be_valid, m_sv);
        chk(be_payload == m_sp, "R10 be_payload", be_payload, m_sp);
        n_sv = m_sv; n_sp = m_sp; n_ph = m_ph; n_ld = m_ld;
        if (acc && (act == 0 || act == 1)) begin
            n_sv = 1; n_sp = payload;
        end else if (m_sv && be_ready) begin
            n_sv = 0;
        end
        if (acc && act == 1) begin n_ph = 1; n_ld = (cls == 2'd1); end
        else if (acc && act == 3) n_ph = 2;
        else if (hit) n_ph = mexc ? 2 : 0;
        else if (m_ph == 2 && be_idle) n_ph = 0;
    endtask

    task automatic adv();
        @(posedge clk);
        if (!rst_n) begin
            m_ph = 0; m_sv = 0; m_sp = '0; m_ld = 0;
        end else begin
            m_ph = n_ph; m_sv = n_sv; m_sp = n_sp; m_ld = n_ld;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        req_valid = 0; cls = 2'd0; illegal = 0; whole = 0; vl_zero = 0;
        res_en = 0; res_in = '0; payload = '0;
        ld_done = 0; st_done = 0; mexc = 0; be_idle = 0;
    endtask

    task automatic offer(input logic [1:0] c, input bit ill, input bit vz,
                         input bit wr, input logic [PW-1:0] p);
        req_valid = 1; cls = c; illegal = ill; vl_zero = vz; whole = wr;
        payload = p; res_en = 1; res_in = {32'hC0DE_0000, p};
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        rst_n = 0; be_ready = 1; quiet();
        m_ph = 0; m_sv = 0; m_sp = '0; m_ld = 0;
        @(negedge clk);
        repeat (3) adv();
        rst_n = 1;

        // R1: state after reset
        probe();
        chk(req_ready == 1, "R1 ready", req_ready, 1);
        chk(be_valid == 0, "R1 be_valid", be_valid, 0);
        chk(resp_valid == 0, "R1 resp_valid", resp_valid, 0);
        chk(be_payload == 0, "R1 payload", be_payload, 0);
        adv();

        // R2 / R3: arithmetic answered at once, forwarded next cycle
        be_ready = 0;
        offer(2'd0, 0, 0, 0, 32'hA11A);
        probe();
        chk(resp_valid && !resp_exc, "R2 arith response", resp_valid, 1);
        chk(res_valid && res_out == {32'hC0DE_0000, 32'hA11A}, "R3 result",
            res_out, {32'hC0DE_0000, 32'hA11A});
        adv();
        quiet();
        probe();
        chk(be_valid && be_payload == 32'hA11A, "R2 forward", be_payload, 32'hA11A);
        chk(req_ready == 0, "R11 blocked by full slot", req_ready, 0);
        adv();
        probe();
        chk(be_valid && be_payload == 32'hA11A, "R10 hold", be_payload, 32'hA11A);
        adv();
        be_ready = 1;
        probe();
        chk(req_ready == 1, "R11 slot draining", req_ready, 1);
        adv();

        // R4 / R5: load waits for load-done, store-done ignored
        offer(2'd1, 0, 0, 0, 32'hB0B0);
        probe();
        chk(resp_valid == 0, "R4 no response at accept", resp_valid, 0);
        adv();
        quiet();
        probe(); adv();
        st_done = 1;
        probe();
        chk(resp_valid == 0, "R5 wrong done ignored", resp_valid, 0);
        chk(req_ready == 0, "R4 blocked while waiting", req_ready, 0);
        adv();
        st_done = 0; ld_done = 1;
        probe();
        chk(resp_valid && !resp_exc, "R5 load done", resp_valid, 1);
        chk(res_valid == 0, "R3 memory no result", res_valid, 0);
        adv();
        quiet();
        probe();
        chk(req_ready == 1, "R5 back to idle", req_ready, 1);
        adv();

        // R6 / R9: illegal, then flush until backend idle
        offer(2'd0, 1, 0, 0, 32'hDEAD);
        probe();
        chk(resp_valid && resp_exc, "R6 illegal flagged", resp_exc, 1);
        adv();
        quiet();
        probe();
        chk(be_valid == 0, "R6 not forwarded", be_valid, 0);
        chk(req_ready == 0, "R9 flush blocks", req_ready, 0);
        adv();
        be_idle = 1;
        probe();
        chk(req_ready == 0, "R9 still flushing", req_ready, 0);
        adv();
        be_idle = 0;
        probe();
        chk(req_ready == 1, "R9 released", req_ready, 1);
        adv();

        // R5 / R9: store ended by an exception
        offer(2'd2, 0, 0, 0, 32'h5707);
        probe(); adv();
        quiet();
        probe(); adv();
        mexc = 1;
        probe();
        chk(resp_valid && resp_exc, "R5 memory exception", resp_exc, 1);
        adv();
        mexc = 0; be_idle = 1;
        probe();
        chk(req_ready == 0, "R9 flush after memory fault", req_ready, 0);
        adv();
        quiet();
        probe(); adv();

        // R7: zero length no-op and illegal precedence
        offer(2'd1, 0, 1, 0, 32'h0F0F);
        probe();
        chk(resp_valid && !resp_exc, "R7 no-op response", resp_valid, 1);
        adv();
        quiet();
        probe();
        chk(be_valid == 0 && req_ready == 1, "R7 no-op not forwarded", be_valid, 0);
        adv();
        offer(2'd0, 1, 1, 0, 32'h1111);
        probe();
        chk(resp_exc == 1, "R7 illegal wins", resp_exc, 1);
        adv();
        quiet(); be_idle = 1;
        probe(); adv();
        quiet();
        probe(); adv();

        // R8: whole-register load with zero length still waits
        offer(2'd1, 0, 1, 1, 32'h3333);
        probe();
        chk(resp_valid == 0, "R8 whole-reg not a no-op", resp_valid, 0);
        adv();
        quiet();
        probe();
        chk(be_valid && be_payload == 32'h3333, "R8 forwarded", be_payload, 32'h3333);
        adv();
        ld_done = 1;
        probe();
        chk(resp_valid == 1, "R8 completes", resp_valid, 1);
        adv();
        quiet();

        // Random traffic checked against the model every cycle.
        for (int i = 0; i < 4000; i++) begin
            req_valid = ($urandom_range(0, 1) == 1);
            cls       = 2'($urandom_range(0, 3));
            illegal   = ($urandom_range(0, 9) == 0);
            vl_zero   = ($urandom_range(0, 6) == 0);
            whole     = ($urandom_range(0, 2) == 0);
            payload   = $urandom;
            res_en    = ($urandom_range(0, 1) == 1);
            res_in    = {$urandom, $urandom};
            be_ready  = ($urandom_range(0, 4) < 3);
            ld_done   = ($urandom_range(0, 4) == 0);
            st_done   = ($urandom_range(0, 4) == 0);
            mexc      = ($urandom_range(0, 9) == 0);
            be_idle   = ($urandom_range(0, 2) == 0);
            probe();
            adv();
        end
        finish_run();
    end

endmodule